// File: doc/BRIEF.md
# SPI Master Peripheral-Select Sequencer

This block drives the four active-low peripheral-select lines of an SPI master. It takes two strobes from the shift engine: one that asks for a transfer to begin and one that says the transfer is over. Between them it holds the chosen select line low. The select code comes from the static configuration word in fixed mode, or from a per-transfer code input in variable mode. The code is turned into output levels in one of two ways. The direct mode picks one line by the position of the lowest zero bit of the code. The decoder mode passes the raw 4-bit code out to an external 4-to-16 decoder, so up to 15 peripherals can be addressed.

After each deselect the block holds all lines high for a guaranteed gap before any line goes low again. This avoids bus contention from slow-floating peripherals. The gap is counted in clock cycles of the block's clock, which runs at the SPI clock. It is the programmed 8-bit delay, but never less than six cycles. A start request that arrives during the gap is kept and carried out the moment the gap ends. The `ready` output tells the shift engine when a start will be taken at once. Codes that select nothing are refused. In direct mode, a refused code raises a one-cycle error pulse.

Top module: `spi_csel_seq`

## Requirements
- R1: After synchronous reset, `sel_n` is 4'b1111, `ready` is 1 and `code_err` is 0.
- R2: In direct mode (`cfg_decode`=0), a granted start drives low only the line whose index equals the lowest zero bit of the code: ???0→1110, ??01→1101, ?011→1011, 0111→0111. The higher bits have no effect.
- R3: In direct mode, code 1111 is refused. `sel_n` stays 1111, and `code_err` is 1 for exactly one cycle, starting on the clock edge after the start is taken.
- R4: In decoder mode (`cfg_decode`=1), a granted start drives `sel_n` with the 4-bit code unchanged.
- R5: In decoder mode, code 1111 is refused. `sel_n` stays 1111 and `code_err` stays 0.
- R6: With `cfg_var_sel`=0 the code is `cfg_code`. With `cfg_var_sel`=1 the code is `var_code`, and `cfg_code` has no effect.
- R7: When `cfg_gap` ≤ 6, a deselect followed by a waiting start keeps `sel_n` at 1111 for exactly 6 cycles.
- R8: When `cfg_gap` > 6, that idle period lasts exactly `cfg_gap` cycles.
- R9: `ready` is 0 while a line is selected and throughout the gap. A start that arrives during the gap is held and carried out when the gap ends.
- R10: Before any selection since reset, no gap applies. A start taken while idle drives `sel_n` low on the next clock edge.
- R11: While a line is selected, `xfer_start` is ignored. While no line is selected, `xfer_end` is ignored. Deselect happens on the edge that samples `xfer_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per SPI clock period |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_var_sel | input | 1 | 0: code from `cfg_code`; 1: code from `var_code` |
| cfg_decode | input | 1 | 0: direct one-low mapping; 1: raw code to external decoder |
| cfg_code | input | 4 | Fixed-mode select code |
| cfg_gap | input | 8 | Programmed idle gap between selects, in cycles |
| var_code | input | 4 | Per-transfer select code for variable mode |
| xfer_start | input | 1 | Transfer start request strobe |
| xfer_end | input | 1 | Transfer end strobe |
| sel_n | output | 4 | Active-low peripheral-select lines |
| ready | output | 1 | High when a start would be taken at once |
| code_err | output | 1 | One-cycle pulse on a refused direct-mode code |

## Verification
Each fault has its own signature at the ports. A wrong select mapping shows on `sel_n` on the edge right after a start is taken. A wrong load or wrong decrement in the gap counter moves the edge where a held start asserts the line, so the high period on `sel_n` becomes longer or shorter than expected. A lost pending request shows as `sel_n` staying at 1111 and `ready` rising while the model expects a selection. The reference model compares `sel_n`, `ready` and `code_err` on every cycle, so any of these faults is reported within one cycle of the edge where it first appears.

// File: rtl/spi_csel_pkg.sv
// Shared definitions for the peripheral-select sequencer.
// Assumes a fixed count of four select lines for the whole block.
package spi_csel_pkg;

    parameter int CS_LINES = 4;

    // One resolved selection: output levels plus its classification.
    typedef struct packed {
        logic [CS_LINES-1:0] lvl_n;   // active-low line levels
        logic                ok;      // selection may be driven
        logic                forbid;  // refused code that must be flagged
    } csel_pick_t;

endpackage

// File: rtl/spi_csel_map.sv
// Select-code mapper: turns a raw code into active-low line levels.
// Direct mode lowers the line at the lowest zero bit of the code; decoder
// mode passes the code through. An all-ones code selects nothing.
// Purely combinational; assumes NCS >= 2.
module spi_csel_map
    import spi_csel_pkg::*;
#(
    parameter int NCS = CS_LINES
) (
    input  logic [NCS-1:0] code,
    input  logic           decode,
    output logic [NCS-1:0] lvl_n,
    output logic           ok,
    output logic           forbid
);

    logic           hit;
    logic [NCS-1:0] one_low;

    // Priority search for the lowest zero bit of the code.
    always_comb begin
        hit     = 1'b0;
        one_low = '1;
        for (int i = 0; i < NCS; i++) begin
            if (!hit && !code[i]) begin
                one_low[i] = 1'b0;
                hit        = 1'b1;
            end
        end
    end

    // Choose between direct and pass-through forms and classify the code.
    always_comb begin
        if (decode) begin
            lvl_n  = code;
            ok     = ~&code;
            forbid = 1'b0;
        end else begin
            lvl_n  = one_low;
            ok     = hit;
            forbid = ~hit;
        end
    end

    // R2: a direct-mode pick lowers exactly one line.
    always_comb begin
        a_r2_single_low : assert (!(ok && !decode) || $onehot(~lvl_n));
    end

endmodule

// File: rtl/spi_csel_gap.sv
// Inter-select gap timer. A load marks a deselect edge. The timer then
// stays busy for max(gap_cfg, MIN_GAP) cycles, and expire is high in its
// last busy cycle. A load always restarts the count.
// Assumes MIN_GAP >= 1 and that MIN_GAP fits in GAP_W bits.
module spi_csel_gap #(
    parameter int GAP_W   = 8,
    parameter int MIN_GAP = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] gap_cfg,
    output logic             busy,
    output logic             expire
);

    localparam logic [GAP_W-1:0] FLOOR = GAP_W'(MIN_GAP);

    logic [GAP_W-1:0] eff_len;
    logic [GAP_W-1:0] remain;
    logic             run;

    // Apply the minimum-length clamp to the programmed gap.
    always_comb begin
        eff_len = (gap_cfg <= FLOOR) ? FLOOR : gap_cfg;
    end

    // Count down from the clamped length; stop once the last cycle is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            remain <= '0;
        end else if (load) begin
            run    <= 1'b1;
            remain <= eff_len - GAP_W'(1);
        end else if (run) begin
            if (remain == '0) run <= 1'b0;
            else              remain <= remain - GAP_W'(1);
        end
    end

    assign busy   = run;
    assign expire = run && (remain == '0);

    // R7: a freshly loaded gap never counts fewer than the floor.
    a_r7_floor_kept : assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (busy && remain >= FLOOR - GAP_W'(1)));

    // R8: a running gap drops by one per cycle until it expires.
    a_r8_steady_count : assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && remain != '0) |=> (remain == $past(remain) - GAP_W'(1)));

endmodule

// File: rtl/spi_csel_seq.sv
// Peripheral-select sequencer top. It selects a line on a start strobe and
// releases it on an end strobe. After each release it enforces the idle
// gap, and it holds one start request that arrives during that gap.
// Assumes the strobes are synchronous to clk and each lasts one cycle.
module spi_csel_seq
    import spi_csel_pkg::*;
#(
    parameter int GAP_W   = 8,
    parameter int MIN_GAP = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_var_sel,
    input  logic                cfg_decode,
    input  logic [CS_LINES-1:0] cfg_code,
    input  logic [GAP_W-1:0]    cfg_gap,
    input  logic [CS_LINES-1:0] var_code,
    input  logic                xfer_start,
    input  logic                xfer_end,
    output logic [CS_LINES-1:0] sel_n,
    output logic                ready,
    output logic                code_err
);

    localparam int NCS = CS_LINES;

    logic [NCS-1:0] live_code;
    csel_pick_t     now_pick;
    csel_pick_t     held_pick;
    csel_pick_t     use_pick;
    logic           held;
    logic           live;
    logic [NCS-1:0] sel_q;
    logic           err_q;
    logic           gap_busy;
    logic           gap_expire;
    logic           release_now;
    logic           may_launch;
    logic           want_launch;

    // Pick the code source for this request.
    assign live_code = cfg_var_sel ? var_code : cfg_code;

    spi_csel_map #(.NCS(NCS)) map_i (
        .code   (live_code),
        .decode (cfg_decode),
        .lvl_n  (now_pick.lvl_n),
        .ok     (now_pick.ok),
        .forbid (now_pick.forbid)
    );

    assign release_now = live && xfer_end;

    spi_csel_gap #(.GAP_W(GAP_W), .MIN_GAP(MIN_GAP)) gap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (release_now),
        .gap_cfg (cfg_gap),
        .busy    (gap_busy),
        .expire  (gap_expire)
    );

    // Decide whether a selection may be driven in this cycle, and which one.
    always_comb begin
        may_launch  = !live && (!gap_busy || gap_expire);
        want_launch = held || xfer_start;
        use_pick    = held ? held_pick : now_pick;
    end

    // Main sequencing: select, release, hold a request during the gap, flag errors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live      <= 1'b0;
            sel_q     <= '1;
            err_q     <= 1'b0;
            held      <= 1'b0;
            held_pick <= '{lvl_n: '1, ok: 1'b0, forbid: 1'b0};
        end else begin
            err_q <= 1'b0;
            if (live) begin
                if (xfer_end) begin
                    live  <= 1'b0;
                    sel_q <= '1;
                end
            end else if (may_launch) begin
                held <= 1'b0;
                if (want_launch) begin
                    if (use_pick.ok) begin
                        live  <= 1'b1;
                        sel_q <= use_pick.lvl_n;
                    end else begin
                        err_q <= use_pick.forbid;
                    end
                end
            end else if (xfer_start && !held) begin
                held      <= 1'b1;
                held_pick <= now_pick;
            end
        end
    end

    assign sel_n    = sel_q;
    assign code_err = err_q;
    assign ready    = !live && !gap_busy;

    // R1: the first cycle after reset shows the idle state.
    a_r1_reset_idle : assert property (@(posedge clk)
        !rst_n |=> (sel_n == '1 && !code_err));

    // R3: the error flag lasts one cycle and never comes with a selection.
    a_r3_err_single : assert property (@(posedge clk) disable iff (!rst_n)
        code_err |=> !code_err);
    a_r3_err_no_sel : assert property (@(posedge clk) disable iff (!rst_n)
        code_err |-> (sel_n == '1));

    // R9: no readiness while a line is selected.
    a_r9_busy_not_ready : assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n != '1) |-> !ready);

    // R9: a release always starts a gap, so readiness cannot return at once.
    a_r9_gap_follows : assert property (@(posedge clk) disable iff (!rst_n)
        release_now |=> (sel_n == '1 && !ready));

    // R11: a selection holds steady until the end strobe.
    a_r11_hold_sel : assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n != '1 && !xfer_end) |=> $stable(sel_n));

endmodule

// File: tb/spi_csel_seq_tb_top.sv
// Testbench: a behavioural reference model is compared with the block on
// every clock, and directed checks cover each requirement.
module spi_csel_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_var_sel = 1'b0;
    logic       cfg_decode = 1'b0;
    logic [3:0] cfg_code = 4'h0;
    logic [7:0] cfg_gap = 8'd0;
    logic [3:0] var_code = 4'h0;
    logic       xfer_start = 1'b0;
    logic       xfer_end = 1'b0;
    logic [3:0] sel_n;
    logic       ready;
    logic       code_err;

    int    errors = 0;
    int    checks = 0;
    string tag = "R1";
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    spi_csel_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_var_sel(cfg_var_sel), .cfg_decode(cfg_decode),
        .cfg_code(cfg_code), .cfg_gap(cfg_gap), .var_code(var_code),
        .xfer_start(xfer_start), .xfer_end(xfer_end),
        .sel_n(sel_n), .ready(ready), .code_err(code_err)
    );

    // ---------------- reference model ----------------
    int   m_edge = 0;
    bit   m_live = 0, m_err = 0, m_relv = 0, m_pend = 0, m_pok = 0, m_pforb = 0;
    logic [3:0] m_sel = 4'hf, m_psel = 4'hf;
    int   m_rel = 0, m_glen = 6;

    // Expected levels for one code, by the mapping rules R2 and R4.
    function automatic void pick(input logic [3:0] c, input bit dec,
                                 output logic [3:0] s, output bit ok, output bit fb);
        if (dec) begin
            s = c; ok = (c != 4'hf); fb = 0;
        end else begin
            casez (c)
                4'b???0: s = 4'b1110;
                4'b??01: s = 4'b1101;
                4'b?011: s = 4'b1011;
                4'b0111: s = 4'b0111;
                default: s = 4'b1111;
            endcase
            ok = (c != 4'hf); fb = (c == 4'hf);
        end
    endfunction

    function automatic bit m_ready();
        return !m_live && !(m_relv && m_edge < m_rel + m_glen);
    endfunction

    always @(posedge clk) begin
        logic [3:0] s; bit ok, fb;
        m_edge++;
        if (!rst_n) begin
            m_live = 0; m_sel = 4'hf; m_err = 0; m_relv = 0; m_pend = 0;
        end else begin
            m_err = 0;
            pick(cfg_var_sel ? var_code : cfg_code, cfg_decode, s, ok, fb);
            if (m_live) begin
                if (xfer_end) begin
                    m_live = 0; m_sel = 4'hf; m_relv = 1; m_rel = m_edge;
                    m_glen = (cfg_gap <= 6) ? 6 : int'(cfg_gap);
                end
            end else if (m_relv && m_edge < m_rel + m_glen) begin
                if (xfer_start && !m_pend) begin
                    m_pend = 1; m_psel = s; m_pok = ok; m_pforb = fb;
                end
            end else if (m_pend || xfer_start) begin
                if (m_pend) begin s = m_psel; ok = m_pok; fb = m_pforb; end
                m_pend = 0;
                if (ok) begin m_live = 1; m_sel = s; end
                else m_err = fb;
            end
        end
    end

    // Compare with the model on every cycle, away from the active edge.
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            checks++;
            if (sel_n !== m_sel || ready !== m_ready() || code_err !== m_err) begin
                errors++;
                $display("FAIL %s edge %0d: sel_n=%b exp %b ready=%b exp %b code_err=%b exp %b",
                         tag, m_edge, sel_n, m_sel, ready, m_ready(), code_err, m_err);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ready();
        for (int k = 0; k < 400 && !ready; k++) tick(1);
    endtask

    // One transfer: start, hold the selection, end, then wait for ready.
    task automatic xfer(input int len);
        xfer_start = 1; tick(1); xfer_start = 0;
        tick(len);
        xfer_end = 1; tick(1); xfer_end = 0;
        wait_ready();
    endtask

    // Measure the idle period when a start waits through the gap.
    task automatic measure(input int g, input int exp, input string req);
        int hi;
        cfg_gap = 8'(g); cfg_code = 4'h0;
        xfer_start = 1; tick(1); xfer_start = 0;
        tick(2);
        xfer_end = 1; tick(1); xfer_end = 0;
        xfer_start = 1;                                  // arrives during the gap
        chk(ready == 0, "R9 ready low in gap", ready, 0);
        hi = (sel_n == 4'hf) ? 1 : 0;
        tick(1); xfer_start = 0;
        while (sel_n == 4'hf && hi < 400) begin hi++; tick(1); end
        chk(hi == exp, req, hi, exp);
        chk(sel_n == 4'b1110, "R9 held start served", sel_n, 4'b1110);
        xfer_end = 1; tick(1); xfer_end = 0;
        wait_ready();
    endtask

    // ---------------- stimulus ----------------
    initial begin
        tick(3);
        cmp_en = 1;
        tag = "R1";
        chk(sel_n == 4'hf && ready && !code_err, "R1 reset state",
            {sel_n, ready, code_err}, {4'hf, 1'b1, 1'b0});
        rst_n = 1; tick(1);

        tag = "R10";
        cfg_code = 4'b1010;
        xfer_start = 1; tick(1); xfer_start = 0;
        chk(sel_n == 4'b1110, "R10 first select no gap", sel_n, 4'b1110);
        tick(1);
        xfer_end = 1; tick(1); xfer_end = 0; wait_ready();

        tag = "R2";
        for (int c = 0; c < 16; c++) begin
            cfg_code = 4'(c);
            if (c == 15) tag = "R3";
            xfer_start = 1; tick(1); xfer_start = 0;
            if (c == 15) begin
                chk(code_err == 1 && sel_n == 4'hf, "R3 forbidden flagged", {sel_n, code_err}, 5'h1f);
                tick(1);
                chk(code_err == 0, "R3 pulse one cycle", code_err, 0);
            end else if (c[0] == 0) begin
                chk(sel_n == 4'b1110, "R2 lowest zero bit0", sel_n, 4'b1110);
            end
            tick(1);
            xfer_end = 1; tick(1); xfer_end = 0; wait_ready();
        end

        tag = "R4";
        cfg_decode = 1;
        for (int c = 0; c < 16; c++) begin
            cfg_code = 4'(c);
            if (c == 15) tag = "R5";
            xfer_start = 1; tick(1); xfer_start = 0;
            if (c == 15) chk(sel_n == 4'hf && code_err == 0, "R5 decode all-ones refused", {sel_n, code_err}, 5'h1e);
            else         chk(sel_n == 4'(c), "R4 raw pass-through", sel_n, c);
            tick(1);
            xfer_end = 1; tick(1); xfer_end = 0; wait_ready();
        end
        cfg_decode = 0;

        tag = "R6";
        cfg_var_sel = 1; cfg_code = 4'b1111; var_code = 4'b0011;
        xfer_start = 1; tick(1); xfer_start = 0;
        chk(sel_n == 4'b1011, "R6 variable code used", sel_n, 4'b1011);
        cfg_code = 4'b0000; tick(1);
        chk(sel_n == 4'b1011, "R6 fixed code ignored", sel_n, 4'b1011);
        xfer_end = 1; tick(1); xfer_end = 0; wait_ready();
        cfg_var_sel = 0;

        tag = "R7";
        measure(0, 6, "R7 gap 0 clamps to 6");
        measure(3, 6, "R7 gap 3 clamps to 6");
        measure(6, 6, "R7 gap 6");
        tag = "R8";
        measure(7, 7, "R8 gap 7");
        measure(13, 13, "R8 gap 13");
        measure(40, 40, "R8 gap 40");

        tag = "R11";
        cfg_gap = 8'd0; cfg_code = 4'b0111;
        xfer_start = 1; tick(1); xfer_start = 0;
        chk(sel_n == 4'b0111, "R2 code 0111", sel_n, 4'b0111);
        cfg_code = 4'b0000;
        xfer_start = 1; tick(1); xfer_start = 0;
        chk(sel_n == 4'b0111, "R11 start ignored while selected", sel_n, 4'b0111);
        xfer_end = 1; tick(1); xfer_end = 0;
        chk(sel_n == 4'hf, "R11 released on end", sel_n, 4'hf);
        wait_ready();
        xfer_end = 1; tick(1); xfer_end = 0;
        chk(ready == 1 && sel_n == 4'hf, "R11 end ignored when idle", {sel_n, ready}, 5'h1f);

        tag = "R9";
        cfg_gap = 8'd9;
        xfer(2);
        chk(ready == 1, "R9 ready after gap", ready, 1);

        tag = "R1";
        rst_n = 0; tick(1); rst_n = 1;
        chk(sel_n == 4'hf && ready, "R1 reset again", {sel_n, ready}, 5'h1f);
        tag = "R10";
        cfg_code = 4'b1101;
        xfer_start = 1; tick(1); xfer_start = 0;
        chk(sel_n == 4'b1101, "R10 no gap after reset", sel_n, 4'b1101);
        tick(2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule